// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps calendar time in binary-coded decimal and presents it as eight byte-wide registers behind a simple synchronous register port. A one-pulse-per-second tick input advances the count. Each tick ripples through seconds, minutes, hours, weekday and date, month and year within a single clock cycle. A century flag can optionally flip when the year wraps. Month length and leap years are handled in the date counter.

Software never sees the counters directly. It reads a user-visible copy that tracks the counters while the copy is unfrozen. Setting the freeze-for-read bit holds the copy so that a multi-byte read is coherent, while the counters keep running underneath. Setting the load bit also holds the copy and opens the time fields for writing. Clearing the load bit copies every time field into the counters in one cycle. A stop bit halts counting entirely. The configuration bits (stop, century enable, frequency test, low-battery enable) take effect on any write, whether or not the load bit is set.

Top module: `bcd_rtc_regfile`

## Requirements
- R1: After reset the eight offsets read 0x00, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00 for offsets 0 to 7. This is 00:00:00, weekday 1, day 01 of month 01, year 00, with every control and configuration bit clear.
- R2: With stop clear, each tick adds one second in BCD. Seconds 59 wraps to 00 and carries into minutes, and minutes 59 wraps and carries into hours. Hours 23 wraps to 00 and advances the date and the weekday together (offset 4 bits 2:0, range 1 to 7, where 7 wraps to 1).
- R3: The date wraps to 01 after the last day of its month and carries the month. Months 04, 06, 09 and 11 have 30 days, and the other months have 31. February has 29 days when the BCD year is divisible by 4 (00 included) and 28 days otherwise. Month 12 wraps to 01 and carries the year, and year 99 wraps to 00.
- R4: When century enable (offset 4 bit 5) is 1, the century flag (offset 4 bit 4) inverts when the year wraps 99 to 00. When century enable is 0, the flag never changes on its own. Century enable and frequency test (offset 4 bit 6) are writable while the load bit is 0.
- R5: While the load bit (offset 0 bit 7) is 1, writes to the time fields of offsets 1 to 7 appear on reads, and the counters keep running unseen. Writing offset 0 with bit 7 = 0 while the load bit is 1 copies all time fields into the counters at once. Later ticks count on from the copied values.
- R6: While the load bit is 0, writes to time fields are ignored. Only the configuration bits in those bytes change.
- R7: While the freeze bit (offset 0 bit 6) is 1, reads of offsets 1 to 7 stay fixed even when ticks arrive. The ticks are still counted, and after the freeze bit is cleared the reads show the advanced time.
- R8: While stop (offset 1 bit 7) is 1, ticks are ignored. Counting resumes from the held value once stop is cleared.
- R9: Unused bits always read 0. These are offset 2 bit 7, offset 3 bits 7:6, offset 4 bits 7 and 3, and offset 6 bits 7:5. The low-battery flag at offset 5 bit 6 also always reads 0. Offset 0 bits 5:0 (calibration sign and magnitude) and offset 5 bit 7 read back as written and do not change counting.
- R10: Read data is registered. It shows the offset that was on the address lines at the previous edge. A tick sampled at edge k becomes visible on read data from edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse once per second |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable, one write per asserted cycle |
| rdata_o | output | 8 | Registered read data |

## Verification
Read data can only show the visible copy. A counter that carries wrongly therefore shows up two cycles after the tick that triggers it. A copy that fails to hold or to follow shows up on the first read after the freeze bit changes. A faulty load shows up on the first read after the load bit is cleared. Checks aimed at month-end dates, leap-year Februaries, the 99-to-00 year wrap with and without century enable, and ticks arriving during freeze and stop expose each of these errors within a few cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_AW = 3;
  localparam int RTC_DW = 8;

  typedef struct packed {
    logic       cb;
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] day;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else return v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [1:0] s;
    s = y[1:0] + {y[4], 1'b0};
    return (s == 2'd0);
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int W = 7
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         inc,
  output logic [W-1:0] nxt,
  output logic         carry
);
  import rtc_pkg::*;
  logic [7:0] ext;
  logic       at_top;

  always_comb begin
    ext    = 8'(cur);
    at_top = (cur == hi);
    carry  = inc & at_top;
    if (!inc)       nxt = cur;
    else if (at_top) nxt = lo;
    else            nxt = W'(bcd_inc(ext));
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      stop,
  input  logic      ceb,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t live
);
  rtc_time_t live_q, cnt_d, live_d;
  logic c_sec, c_min, c_hr, c_date, c_mon, c_yr, c_day;
  logic adv;
  logic [5:0] last_day;

  assign adv      = tick & ~stop;
  assign last_day = month_last(live_q.month, live_q.year);

  rtc_bcd_field #(.W(7)) u_sec (
    .cur(live_q.sec), .lo(7'h00), .hi(7'h59), .inc(adv),
    .nxt(cnt_d.sec), .carry(c_sec));
  rtc_bcd_field #(.W(7)) u_min (
    .cur(live_q.min), .lo(7'h00), .hi(7'h59), .inc(c_sec),
    .nxt(cnt_d.min), .carry(c_min));
  rtc_bcd_field #(.W(6)) u_hour (
    .cur(live_q.hour), .lo(6'h00), .hi(6'h23), .inc(c_min),
    .nxt(cnt_d.hour), .carry(c_hr));
  rtc_bcd_field #(.W(3)) u_day (
    .cur(live_q.day), .lo(3'd1), .hi(3'd7), .inc(c_hr),
    .nxt(cnt_d.day), .carry(c_day));
  rtc_bcd_field #(.W(6)) u_date (
    .cur(live_q.date), .lo(6'h01), .hi(last_day), .inc(c_hr),
    .nxt(cnt_d.date), .carry(c_date));
  rtc_bcd_field #(.W(5)) u_month (
    .cur(live_q.month), .lo(5'h01), .hi(5'h12), .inc(c_date),
    .nxt(cnt_d.month), .carry(c_mon));
  rtc_bcd_field #(.W(8)) u_year (
    .cur(live_q.year), .lo(8'h00), .hi(8'h99), .inc(c_mon),
    .nxt(cnt_d.year), .carry(c_yr));

  always_comb begin
    cnt_d.cb = live_q.cb ^ (c_yr & ceb);
    live_d   = load ? load_val : cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '{cb: 1'b0, year: 8'h00, month: 5'h01, date: 6'h01,
                  day: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00};
    end else begin
      live_q <= live_d;
    end
  end

  assign live = live_q;
  logic unused_day_carry;
  assign unused_day_carry = c_day;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RTC_AW-1:0] addr,
  input  logic [RTC_DW-1:0] wdata,
  input  logic              we,
  input  rtc_time_t         live,
  output rtc_time_t         shadow,
  output logic              commit,
  output logic              ctrl_rd,
  output logic              stop_en,
  output logic              cent_en,
  output logic [RTC_DW-1:0] rdata
);
  logic       wr_q, rd_q, sgn_q, stop_q, ft_q, ceb_q, ble_q;
  logic       wr_d, rd_d, sgn_d, stop_d, ft_d, ceb_d, ble_d;
  logic [4:0] cal_q, cal_d;
  rtc_time_t  sh_q, sh_d;
  logic [RTC_DW-1:0] rsel, rdata_q;
  logic frozen;

  always_comb begin
    frozen = wr_q | rd_q;
    commit = we & (addr == 3'd0) & wr_q & ~wdata[7];
    wr_d = wr_q; rd_d = rd_q; sgn_d = sgn_q; cal_d = cal_q;
    stop_d = stop_q; ft_d = ft_q; ceb_d = ceb_q; ble_d = ble_q;
    sh_d = frozen ? sh_q : live;
    if (we) begin
      case (addr)
        3'd0: begin
          wr_d = wdata[7]; rd_d = wdata[6]; sgn_d = wdata[5]; cal_d = wdata[4:0];
        end
        3'd1: stop_d = wdata[7];
        3'd4: begin ft_d = wdata[6]; ceb_d = wdata[5]; end
        3'd5: ble_d = wdata[7];
        default: ;
      endcase
      if (wr_q) begin
        case (addr)
          3'd1: sh_d.sec   = wdata[6:0];
          3'd2: sh_d.min   = wdata[6:0];
          3'd3: sh_d.hour  = wdata[5:0];
          3'd4: begin sh_d.cb = wdata[4]; sh_d.day = wdata[2:0]; end
          3'd5: sh_d.date  = wdata[5:0];
          3'd6: sh_d.month = wdata[4:0];
          3'd7: sh_d.year  = wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rsel = {wr_q, rd_q, sgn_q, cal_q};
      3'd1:    rsel = {stop_q, sh_q.sec};
      3'd2:    rsel = {1'b0, sh_q.min};
      3'd3:    rsel = {2'b00, sh_q.hour};
      3'd4:    rsel = {1'b0, ft_q, ceb_q, sh_q.cb, 1'b0, sh_q.day};
      3'd5:    rsel = {ble_q, 1'b0, sh_q.date};
      3'd6:    rsel = {3'b000, sh_q.month};
      default: rsel = sh_q.year;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0; rd_q <= 1'b0; sgn_q <= 1'b0; cal_q <= '0;
      stop_q <= 1'b0; ft_q <= 1'b0; ceb_q <= 1'b0; ble_q <= 1'b0;
      sh_q <= '{cb: 1'b0, year: 8'h00, month: 5'h01, date: 6'h01,
                day: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00};
      rdata_q <= '0;
    end else begin
      wr_q <= wr_d; rd_q <= rd_d; sgn_q <= sgn_d; cal_q <= cal_d;
      stop_q <= stop_d; ft_q <= ft_d; ceb_q <= ceb_d; ble_q <= ble_d;
      sh_q <= sh_d;
      rdata_q <= rsel;
    end
  end

  assign shadow  = sh_q;
  assign ctrl_rd = rd_q;
  assign stop_en = stop_q;
  assign cent_en = ceb_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/bcd_rtc_regfile.sv
module bcd_rtc_regfile
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [RTC_AW-1:0] addr_i,
  input  logic [RTC_DW-1:0] wdata_i,
  input  logic              we_i,
  output logic [RTC_DW-1:0] rdata_o
);
  logic [SYNC_STAGES-1:0] rs_q;
  logic      rst_sync_n;
  rtc_time_t live, shadow;
  logic      commit, ctrl_rd, stop_en, cent_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rs_q[SYNC_STAGES-1];

  rtc_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(addr_i), .wdata(wdata_i), .we(we_i),
    .live(live), .shadow(shadow), .commit(commit), .ctrl_rd(ctrl_rd),
    .stop_en(stop_en), .cent_en(cent_en), .rdata(rdata_o));

  rtc_time_chain u_chain (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick_i), .stop(stop_en),
    .ceb(cent_en), .load(commit), .load_val(shadow), .live(live));
endmodule

// File: rtl/bcd_rtc_regfile_chk.sv
module bcd_rtc_regfile_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [RTC_AW-1:0] addr,
  input logic [RTC_DW-1:0] rdata,
  input logic              ctrl_rd,
  input logic              commit,
  input logic              stop_en,
  input logic              cent_en,
  input rtc_time_t         shadow,
  input rtc_time_t         live
);
  p_freeze_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_rd) && !$past(we)) |-> $stable(shadow));

  p_commit_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (live == $past(shadow)));

  p_stop_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_en && !commit) |=> $stable(live));

  p_century_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cent_en && !commit) |=> $stable(live.cb));

  p_min_top_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addr) == 3'd2) |-> !rdata[7]);

  p_batt_flag_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addr) == 3'd5) |-> !rdata[6]);
endmodule

bind bcd_rtc_regfile bcd_rtc_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .we(we_i), .addr(addr_i), .rdata(rdata_o),
  .ctrl_rd(ctrl_rd), .commit(commit), .stop_en(stop_en), .cent_en(cent_en),
  .shadow(shadow), .live(live));

// File: tb/bcd_rtc_regfile_tb.sv
`timescale 1ns/1ps
module bcd_rtc_regfile_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_rtc_regfile u_dut (.clk(clk), .rst_n(rst_n), .tick_i(tick), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata));

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req, input string what);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req, input string what);
    logic [7:0] v;
    rd(a, v);
    chk(v, e, req, what);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] o4, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(0, 8'h80); wr(1, s); wr(2, m); wr(3, h); wr(4, o4);
    wr(5, dt); wr(6, mo); wr(7, y); wr(0, 8'h00);
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int m, input logic [7:0] y);
    int yb;
    yb = int'(y[7:4]) * 10 + int'(y[3:0]);
    if (m == 2) return (yb % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic t_reset;
    logic [7:0] exp [8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    for (int a = 0; a < 8; a++) expect_reg(3'(a), exp[a], "R1", $sformatf("reset offset %0d", a));
  endtask

  task automatic t_carry;
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h21);
    pulse(1);
    expect_reg(1, 8'h59, "R2", "seconds step");
    pulse(1);
    expect_reg(1, 8'h00, "R2", "seconds wrap");
    expect_reg(2, 8'h00, "R2", "minutes wrap");
    expect_reg(3, 8'h00, "R2", "hours wrap");
    expect_reg(4, 8'h01, "R2", "weekday 7 to 1");
    expect_reg(5, 8'h16, "R2", "date advance");
    set_time(8'h59, 8'h09, 8'h09, 8'h03, 8'h10, 8'h05, 8'h21);
    pulse(1);
    expect_reg(2, 8'h10, "R2", "minute 09 to 10");
    expect_reg(3, 8'h09, "R2", "hour unchanged");
  endtask

  task automatic t_months;
    for (int m = 1; m <= 12; m++) begin
      set_time(8'h59, 8'h59, 8'h23, 8'h01, to_bcd(days_in(m, 8'h23)), to_bcd(m), 8'h23);
      pulse(1);
      expect_reg(5, 8'h01, "R3", $sformatf("date wrap month %0d", m));
      expect_reg(6, to_bcd(m == 12 ? 1 : m + 1), "R3", $sformatf("month carry %0d", m));
    end
    expect_reg(7, 8'h24, "R3", "year carry");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    pulse(1);
    expect_reg(5, 8'h29, "R3", "leap feb 28 to 29");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    pulse(1);
    expect_reg(5, 8'h29, "R3", "year 00 leap");
    pulse(86400);
    expect_reg(5, 8'h01, "R3", "feb 29 to march 1");
    expect_reg(6, 8'h03, "R3", "month to 03");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
    pulse(1);
    expect_reg(5, 8'h01, "R3", "non-leap year 10");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    pulse(1);
    expect_reg(7, 8'h00, "R3", "year 99 to 00");
  endtask

  task automatic t_century;
    set_time(8'h59, 8'h59, 8'h23, 8'h27, 8'h31, 8'h12, 8'h99);
    pulse(1);
    expect_reg(4, 8'h31, "R4", "century flips when enabled");
    wr(4, 8'h00);
    expect_reg(4, 8'h11, "R4", "enable cleared without load bit");
    set_time(8'h59, 8'h59, 8'h23, 8'h17, 8'h31, 8'h12, 8'h99);
    pulse(1);
    expect_reg(4, 8'h11, "R4", "century held when disabled");
    wr(4, 8'h40);
    expect_reg(4, 8'h51, "R4", "frequency test writable");
  endtask

  task automatic t_load;
    set_time(8'h10, 8'h20, 8'h05, 8'h01, 8'h01, 8'h01, 8'h30);
    wr(0, 8'h80);
    wr(1, 8'h05);
    expect_reg(1, 8'h05, "R5", "written seconds visible");
    pulse(2);
    expect_reg(1, 8'h05, "R5", "held during load");
    wr(2, 8'h44);
    wr(0, 8'h00);
    expect_reg(1, 8'h05, "R5", "seconds committed");
    expect_reg(2, 8'h44, "R5", "minutes committed");
    pulse(1);
    expect_reg(1, 8'h06, "R5", "counts from committed");
  endtask

  task automatic t_ignored;
    set_time(8'h30, 8'h12, 8'h08, 8'h02, 8'h04, 8'h06, 8'h40);
    wr(2, 8'h45);
    expect_reg(2, 8'h12, "R6", "minute write ignored");
    wr(7, 8'h77);
    expect_reg(7, 8'h40, "R6", "year write ignored");
    wr(1, 8'h05);
    expect_reg(1, 8'h30, "R6", "seconds write ignored");
  endtask

  task automatic t_freeze;
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(0, 8'h40);
    pulse(3);
    expect_reg(1, 8'h10, "R7", "frozen read");
    expect_reg(0, 8'h40, "R7", "freeze bit visible");
    wr(0, 8'h00);
    expect_reg(1, 8'h13, "R7", "ticks kept during freeze");
  endtask

  task automatic t_stop;
    set_time(8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(1, 8'h80);
    pulse(2);
    expect_reg(1, 8'hA0, "R8", "stopped seconds");
    wr(1, 8'h00);
    pulse(1);
    expect_reg(1, 8'h21, "R8", "resume after stop");
  endtask

  task automatic t_mbz;
    wr(0, 8'h80);
    wr(2, 8'hFF); expect_reg(2, 8'h7F, "R9", "minutes unused bit");
    wr(3, 8'hFF); expect_reg(3, 8'h3F, "R9", "hours unused bits");
    wr(4, 8'hFF); expect_reg(4, 8'h77, "R9", "offset 4 unused bits");
    wr(5, 8'hFF); expect_reg(5, 8'hBF, "R9", "battery flag reads 0");
    wr(6, 8'hFF); expect_reg(6, 8'h1F, "R9", "month unused bits");
    wr(0, 8'h00);
    set_time(8'h40, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(0, 8'h3F);
    expect_reg(0, 8'h3F, "R9", "calibration readback");
    pulse(1);
    expect_reg(1, 8'h41, "R9", "calibration has no effect");
    wr(0, 8'h00);
  endtask

  task automatic t_latency;
    set_time(8'h07, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    @(negedge clk); addr = 3'd1; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk(rdata, 8'h07, "R10", "edge k old value");
    @(negedge clk);
    chk(rdata, 8'h07, "R10", "edge k+1 old value");
    @(negedge clk);
    chk(rdata, 8'h08, "R10", "edge k+2 new value");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_carry();
    t_months();
    t_century();
    t_load();
    t_ignored();
    t_freeze();
    t_stop();
    t_mbz();
    t_latency();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule